// File: doc/BRIEF.md
# Truth-Table Fitness Evaluator

This block grades a configured candidate circuit against a stored target truth table. After a start strobe it walks the input space of the circuit in ascending order and presents one input vector per clock cycle on its drive port. The candidate circuit returns its output a fixed number of cycles later. The evaluator delays each expected table entry by that same latency and compares it with the returned output. Presenting new vectors and checking earlier results therefore overlap, so one training vector is scored per cycle.

Scoring is per output bit. Each bit of the returned output that equals the matching bit of the table entry adds one to the fitness count. With the default 4-bit input (16 vectors) and 4-bit output, a perfect candidate scores 64. A host loads the target table through a simple write port while the evaluator is idle. It then starts a run and reads the fitness once the done pulse appears. A separate flag shows whether the score is perfect.

Top module: `tt_fitness_eval`

## Requirements
- R1: After reset the fitness reads 0, done is low and the drive vector is 0.
- R2: When start is accepted, the drive vector shows the values 0 up to N-1 (N = 2^IN_W, 16 by default) in ascending order. It holds each value for one cycle and shows value 0 in the first cycle after the clock edge that sampled start. While no run is in progress the drive vector is 0.
- R3: The circuit output for a vector is taken exactly LAT cycles (default 8) after that vector appears on the drive port. It is compared bit by bit with the table entry whose address equals the vector value, and each equal bit adds one to the fitness.
- R4: The final fitness is the sum of the equal-bit counts over all N vectors. It never exceeds N*OUT_W, which is 64 by default.
- R5: The fitness reads 0 in the first cycle after start is accepted.
- R6: Done is high for exactly one cycle. That cycle comes N+LAT cycles after the edge that sampled start, and the fitness then holds the final score.
- R7: The perfect flag is high exactly when the fitness equals N*OUT_W.
- R8: A table write (tbl_we high, tbl_addr selecting the entry for that vector value, tbl_wdata the expected output) takes effect only when no run is in progress. Writes during a run are ignored.
- R9: A start strobe during a run in progress is ignored. The run finishes with one done pulse and an unchanged score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an evaluation run (accepted when idle) |
| cut_out | input | OUT_W | Output returned by the candidate circuit |
| tbl_we | input | 1 | Target table write enable |
| tbl_addr | input | IN_W | Target table entry (vector value) |
| tbl_wdata | input | OUT_W | Expected output for that vector |
| cut_in | output | IN_W | Input vector driven into the candidate circuit |
| fitness | output | FIT_W | Accumulated count of matching output bits |
| done | output | 1 | One-cycle pulse after the last comparison |
| perfect | output | 1 | Fitness equals the maximum score |

## Verification
On every cycle, the in-line assertions check several properties. Consecutive drive vectors must step by one during a run. The score may grow by at most OUT_W per cycle and never pass the maximum. The score must be cleared right after an accepted start, and done must never last two cycles. The bench's scenarios are needed to show the rest: the latency alignment between vectors and table entries, and the exact final scores for exact, faulty and inverted candidates. They also show that writes and starts issued mid-run are ignored, and that done appears in the right cycle.

// File: rtl/tt_fit_pkg.sv
package tt_fit_pkg;

  // number of equal bits among the low w bits of a and b
  function automatic int unsigned count_match(input logic [31:0] a,
                                              input logic [31:0] b,
                                              input int unsigned w);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if ((i < w) && (a[i] == b[i])) n++;
    end
    return n;
  endfunction

  // highest score a run can reach
  function automatic int unsigned max_score(input int unsigned in_w,
                                            input int unsigned out_w);
    return (32'd1 << in_w) * out_w;
  endfunction

endpackage

// File: rtl/tt_target_ram.sv
module tt_target_ram #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tt_vec_seq.sv
module tt_vec_seq #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          running,
  output logic [AW-1:0] idx,
  output logic          last
);
  localparam logic [AW-1:0] IDX_END = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
    end else if (go) begin
      running <= 1'b1;
      idx     <= '0;
    end else if (running) begin
      if (idx == IDX_END) begin
        running <= 1'b0;
        idx     <= '0;
      end else begin
        idx <= idx + AW'(1);
      end
    end
  end

  assign last = running && (idx == IDX_END);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> (idx == $past(idx) + AW'(1)));
endmodule

// File: rtl/tt_delay_line.sv
module tt_delay_line #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         in_last,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic         out_last,
  output logic [W-1:0] out_data,
  output logic         any_vld
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] last_q;
  logic [W-1:0]     data_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[0]  <= 1'b0;
          last_q[0] <= 1'b0;
          data_q[0] <= '0;
        end else begin
          vld_q[0]  <= in_vld;
          last_q[0] <= in_last;
          data_q[0] <= in_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s]  <= 1'b0;
          last_q[s] <= 1'b0;
          data_q[s] <= '0;
        end else begin
          vld_q[s]  <= vld_q[s-1];
          last_q[s] <= last_q[s-1];
          data_q[s] <= data_q[s-1];
        end
      end
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_last = last_q[DEPTH-1];
  assign out_data = data_q[DEPTH-1];
  assign any_vld  = |vld_q;
endmodule

// File: rtl/tt_score_acc.sv
module tt_score_acc
  import tt_fit_pkg::*;
#(
  parameter int OUT_W = 4,
  parameter int FIT_W = 7,
  parameter int MAXV  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cmp_vld,
  input  logic             cmp_last,
  input  logic [OUT_W-1:0] y,
  input  logic [OUT_W-1:0] d,
  output logic [FIT_W-1:0] fitness,
  output logic             done
);
  logic [FIT_W-1:0] gain;

  assign gain = FIT_W'(count_match(32'(y), 32'(d), OUT_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fitness <= '0;
      done    <= 1'b0;
    end else begin
      if (clear)        fitness <= '0;
      else if (cmp_vld) fitness <= fitness + gain;
      done <= cmp_vld && cmp_last;
    end
  end

  p_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((fitness - $past(fitness)) <= FIT_W'(OUT_W)));
  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fitness <= FIT_W'(MAXV));
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tt_fitness_eval.sv
module tt_fitness_eval
  import tt_fit_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int OUT_W = 4,
  parameter int LAT   = 8,
  localparam int MAXV  = (1 << IN_W) * OUT_W,
  localparam int FIT_W = $clog2(MAXV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OUT_W-1:0] cut_out,
  input  logic             tbl_we,
  input  logic [IN_W-1:0]  tbl_addr,
  input  logic [OUT_W-1:0] tbl_wdata,
  output logic [IN_W-1:0]  cut_in,
  output logic [FIT_W-1:0] fitness,
  output logic             done,
  output logic             perfect
);
  // named internal events
  logic             running;
  logic [IN_W-1:0]  idx;
  logic             issue_last;
  logic             line_busy;
  logic             busy;
  logic             go;
  logic             ram_we;
  logic [OUT_W-1:0] exp_now;
  logic             cmp_vld;
  logic             cmp_last;
  logic [OUT_W-1:0] exp_dly;

  assign busy   = running | line_busy;
  assign go     = start & ~busy;
  assign ram_we = tbl_we & ~busy;

  tt_target_ram #(.AW(IN_W), .DW(OUT_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (idx),
    .rdata (exp_now)
  );

  tt_vec_seq #(.AW(IN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .running (running),
    .idx     (idx),
    .last    (issue_last)
  );

  tt_delay_line #(.W(OUT_W), .DEPTH(LAT)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (running),
    .in_last  (issue_last),
    .in_data  (exp_now),
    .out_vld  (cmp_vld),
    .out_last (cmp_last),
    .out_data (exp_dly),
    .any_vld  (line_busy)
  );

  tt_score_acc #(.OUT_W(OUT_W), .FIT_W(FIT_W), .MAXV(MAXV)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .cmp_vld  (cmp_vld),
    .cmp_last (cmp_last),
    .y        (cut_out),
    .d        (exp_dly),
    .fitness  (fitness),
    .done     (done)
  );

  assign cut_in  = running ? idx : '0;
  assign perfect = (fitness == FIT_W'(max_score(IN_W, OUT_W)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (fitness == '0));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> !$rose(cut_in == '0) || (cut_in == '0 && $past(cut_in) == '0));
endmodule

// File: tb/sim_tt_fitness_eval.sv
module sim_tt_fitness_eval;
  localparam int IN_W  = 4;
  localparam int OUT_W = 4;
  localparam int LAT   = 8;
  localparam int N     = 1 << IN_W;
  localparam int MAXV  = N * OUT_W;
  localparam int FIT_W = $clog2(MAXV + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [OUT_W-1:0] cut_out;
  logic             tbl_we = 1'b0;
  logic [IN_W-1:0]  tbl_addr = '0;
  logic [OUT_W-1:0] tbl_wdata = '0;
  logic [IN_W-1:0]  cut_in;
  logic [FIT_W-1:0] fitness;
  logic             done;
  logic             perfect;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int fault_mode = 0;
  logic [OUT_W-1:0] tbl_shadow [N];
  logic [OUT_W-1:0] pipe [LAT];

  always #4 clk = ~clk;

  tt_fitness_eval #(.IN_W(IN_W), .OUT_W(OUT_W), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cut_out(cut_out),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .cut_in(cut_in), .fitness(fitness), .done(done), .perfect(perfect)
  );

  // candidate circuit model: 2x2 multiplier, optional fault, LAT stages
  function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] v, input int mode);
    logic [OUT_W-1:0] p;
    p = OUT_W'(v[3:2]) * OUT_W'(v[1:0]);
    if (mode == 1) p[0] = 1'b1;
    if (mode == 2) p = p ^ 4'b0110;
    return p;
  endfunction

  always @(posedge clk) begin
    pipe[0] <= model(cut_in, fault_mode);
    for (int j = 1; j < LAT; j++) pipe[j] <= pipe[j-1];
  end
  assign cut_out = pipe[LAT-1];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expected_score(input int mode);
    int s;
    s = 0;
    for (int v = 0; v < N; v++) begin
      logic [OUT_W-1:0] y;
      y = model(IN_W'(v), mode);
      for (int b = 0; b < OUT_W; b++)
        if (y[b] == tbl_shadow[v][b]) s++;
    end
    return s;
  endfunction

  task automatic load_table(input int kind);
    for (int v = 0; v < N; v++) begin
      logic [OUT_W-1:0] p;
      p = OUT_W'(v >> 2) * OUT_W'(v & 3);
      case (kind)
        0: tbl_shadow[v] = p;
        1: tbl_shadow[v] = '0;
        2: tbl_shadow[v] = ~p;
        default: tbl_shadow[v] = OUT_W'(v * 7 + 3);
      endcase
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = IN_W'(v); tbl_wdata = tbl_shadow[v];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // mid_start: pulse start during run (R9); mid_write: attempt a write during run (R8)
  task automatic run_eval(input int mode, input bit mid_start, input bit mid_write);
    int exp_s;
    int cyc;
    bit seen;
    fault_mode = mode;
    exp_s = expected_score(mode);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fitness == 0, "R5 cleared after start", int'(fitness), 0);
    cyc = 0;
    seen = 0;
    while (cyc < N + LAT + 4) begin
      if (cyc < N) chk(cut_in == IN_W'(cyc), "R2 drive order", int'(cut_in), cyc);
      if (done) begin
        seen = 1;
        break;
      end
      if (cyc == 5 && mid_start) start = 1'b1;
      if (cyc == 6 && mid_write) begin
        tbl_we = 1'b1; tbl_addr = 4'd9; tbl_wdata = ~tbl_shadow[9];
      end
      @(negedge clk);
      start = 1'b0;
      tbl_we = 1'b0;
      cyc++;
    end
    chk(seen && cyc == N + LAT, "R6 done timing", cyc, N + LAT);
    chk(fitness == FIT_W'(exp_s), "R3 R4 final score", int'(fitness), exp_s);
    chk(perfect == (exp_s == MAXV), "R7 perfect flag", int'(perfect), int'(exp_s == MAXV));
    @(negedge clk);
    chk(!done, "R6 single pulse", int'(done), 0);
    chk(cut_in == 0, "R2 idle drive", int'(cut_in), 0);
    chk(fitness == FIT_W'(exp_s), "R4 score held", int'(fitness), exp_s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fitness == 0, "R1 reset fitness", int'(fitness), 0);
    chk(!done, "R1 reset done", int'(done), 0);
    chk(cut_in == 0, "R1 reset drive", int'(cut_in), 0);
    rst_n = 1'b1;
    @(negedge clk);

    load_table(0);
    run_eval(0, 0, 0);   // exact candidate: 64, perfect
    run_eval(1, 0, 0);   // stuck low bit
    run_eval(2, 0, 0);   // two inverted bits
    load_table(1);
    run_eval(0, 0, 0);   // all-zero target
    load_table(2);
    run_eval(0, 0, 0);   // inverted target: 0
    load_table(3);
    run_eval(1, 0, 0);   // arbitrary target
    load_table(0);
    run_eval(0, 1, 0);   // R9: mid-run start ignored
    run_eval(0, 0, 1);   // R8: mid-run write ignored
    run_eval(0, 0, 0);   // R8: table still intact
    // R8: idle write takes effect
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'd9; tbl_wdata = ~tbl_shadow[9];
    tbl_shadow[9] = ~tbl_shadow[9];
    @(negedge clk);
    tbl_we = 1'b0;
    run_eval(0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule